// File: doc/BRIEF.md
# Fixed-Point Precision Converter

This block takes a fixed-point sample with a parameterized width, binary point and signedness, and re-expresses it in a different fixed-point format. Low-order bits that the new format cannot hold are removed under a run-time quantization choice: plain truncation, or round-to-nearest with exact halves moved away from zero. High-order overflow is then resolved under a run-time overflow choice: clamp to the nearest representable extreme, or keep only the low output bits.

Each sample travels with a valid bit. The result, its valid bit and an overflow indication pass through a parameterized register delay before they reach the outputs. The block is meant to sit at the narrowing points of a datapath, such as after a multiplier, inside an accumulator feedback path, or at an output gateway. At each of these points the designer picks the width and the quantization and overflow behaviour that the system can afford.

Top module: `fxc_convert`

## Requirements
- R1: An input whose value, in units of 2^-OUT_FRAC, is an integer inside the output range is reproduced exactly. The value of a word is word/2^FRAC, with IN_FRAC in [0, IN_W] and OUT_FRAC in [0, OUT_W]. Default format: signed 12-bit input with 6 fraction bits, and output with 8 bits and 3 fraction bits.
- R2: With quant_sel = 0 (truncate), the bits below the output LSB are dropped, which gives the largest representable value not above the input (floor).
- R3: With quant_sel = 1 (round), the result is the nearest representable value. An exact half goes to the value farther from zero.
- R4: Rounding is applied before the range check, so a carry that rounding produces can cause an overflow, and that overflow is then clamped or wrapped.
- R5: With ovf_sel = 1 (saturate), a value above the output range gives the largest output code, and a value below it gives the smallest (0x7F and 0x80 for a signed 8-bit output).
- R6: With ovf_sel = 0 (wrap), the output is the low OUT_W bits of the two's complement result.
- R7: For an unsigned output (OUT_SIGNED = 0), negative values saturate to 0, and values above 2^OUT_W-1 saturate to all ones.
- R8: out_ovf is 1 for a valid sample exactly when its quantized value falls outside the output range, in either overflow mode. It is 0 for an in-range sample that follows.
- R9: A sample presented with in_valid = 0 leaves the block with out_valid = 0 and out_ovf = 0.
- R10: Outputs follow their inputs after LATENCY clock cycles (default 1). An active reset clears out_valid, out_ovf and out_data to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | IN_W | Input sample |
| in_valid | input | 1 | Input sample valid |
| quant_sel | input | 1 | 0 truncate, 1 round half away from zero |
| ovf_sel | input | 1 | 0 wrap, 1 saturate |
| out_data | output | OUT_W | Converted sample |
| out_valid | output | 1 | Output sample valid |
| out_ovf | output | 1 | Sample was out of output range |

## Verification
The main function is exercised with values that need no quantization, values just above and below a half step of either sign, and exact ties. Together these separate truncation from rounding and show which way ties go. Values at the exact range limits, one step beyond them, and far beyond them run under both overflow modes; this separates clamping from wrapping and shows whether the overflow flag tracks the range. One input rounds across the positive limit only in round mode, which proves that rounding comes before the range check. A second instance with an unsigned output checks that negatives clamp to zero and that the top code is reached without a false overflow.

// File: rtl/fxc_pkg.sv
package fxc_pkg;

    typedef enum logic {
        QM_TRUNC = 1'b0,
        QM_ROUND = 1'b1
    } quant_mode_e;

    typedef enum logic {
        OM_WRAP = 1'b0,
        OM_SAT  = 1'b1
    } ovf_mode_e;

    function automatic int fxc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Left shift needed when the output carries more fraction bits.
    function automatic int fxc_lshift(input int in_frac, input int out_frac);
        return (out_frac > in_frac) ? (out_frac - in_frac) : 0;
    endfunction

endpackage

// File: rtl/fxc_quantize.sv
module fxc_quantize
    import fxc_pkg::*;
#(
    parameter int IN_W      = 12,
    parameter int IN_FRAC   = 6,
    parameter bit IN_SIGNED = 1'b1,
    parameter int OUT_FRAC  = 3,
    parameter int WW        = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IN_W-1:0]      din,
    input  quant_mode_e          qmode,
    output logic signed [WW-1:0] aligned
);

    localparam int SHIFT = IN_FRAC - OUT_FRAC;

    logic signed [WW-1:0] ext;

    generate
        if (IN_SIGNED) begin : g_sext
            assign ext = {{(WW-IN_W){din[IN_W-1]}}, din};
        end else begin : g_zext
            assign ext = {{(WW-IN_W){1'b0}}, din};
        end
    endgenerate

    generate
        if (SHIFT > 0) begin : g_drop
            localparam logic signed [WW-1:0] HALF = WW'(1) <<< (SHIFT-1);
            localparam logic signed [WW-1:0] STEP = WW'(1) <<< SHIFT;

            logic signed [WW-1:0] bias;
            logic signed [WW-1:0] biased;
            logic signed [WW-1:0] back;
            logic signed [WW-1:0] resid;

            always_comb begin
                if (qmode == QM_ROUND) begin
                    bias = ext[WW-1] ? (HALF - WW'(1)) : HALF;
                end else begin
                    bias = '0;
                end
                biased  = ext + bias;
                aligned = biased >>> SHIFT;
            end

            assign back  = aligned <<< SHIFT;
            assign resid = ext - back;

            AST_TRUNC_FLOOR: assert property (@(posedge clk) disable iff (rst) (qmode == QM_TRUNC) |-> (resid >= 0 && resid < STEP)); // R2
            AST_ROUND_NEAREST: assert property (@(posedge clk) disable iff (rst) (qmode == QM_ROUND) |-> (resid >= -HALF && resid <= HALF)); // R3
            AST_ROUND_TIE_AWAY: assert property (@(posedge clk) disable iff (rst) (qmode == QM_ROUND && (resid == HALF || resid == -HALF)) |-> (ext[WW-1] ? (resid == HALF) : (resid == -HALF))); // R3
        end else if (SHIFT == 0) begin : g_same
            assign aligned = ext;
        end else begin : g_widen
            assign aligned = ext <<< (-SHIFT);
        end
    endgenerate

endmodule

// File: rtl/fxc_overflow.sv
module fxc_overflow
    import fxc_pkg::*;
#(
    parameter int WW         = 14,
    parameter int OUT_W      = 8,
    parameter bit OUT_SIGNED = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [WW-1:0] aligned,
    input  ovf_mode_e            omode,
    output logic [OUT_W-1:0]     data,
    output logic                 out_of_range
);

    localparam logic signed [WW-1:0] HI = OUT_SIGNED
        ? {{(WW-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}}
        : {{(WW-OUT_W){1'b0}}, {OUT_W{1'b1}}};
    localparam logic signed [WW-1:0] LO = OUT_SIGNED
        ? {{(WW-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}}
        : '0;

    logic above;
    logic below;

    always_comb begin
        above        = aligned > HI;
        below        = aligned < LO;
        out_of_range = above | below;
        if (omode == OM_SAT && above) begin
            data = HI[OUT_W-1:0];
        end else if (omode == OM_SAT && below) begin
            data = LO[OUT_W-1:0];
        end else begin
            data = aligned[OUT_W-1:0];
        end
    end

    generate
        if (OUT_SIGNED) begin : g_sgn_chk
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) !out_of_range |-> ($signed(data) == aligned)); // R1
        end else begin : g_uns_chk
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) !out_of_range |-> ($signed({1'b0, data}) == aligned)); // R1
            AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (rst) (omode == OM_SAT && aligned < 0) |-> (data == '0)); // R7
        end
    endgenerate

    AST_SAT_EXTREME: assert property (@(posedge clk) disable iff (rst) (omode == OM_SAT && out_of_range) |-> (data == HI[OUT_W-1:0] || data == LO[OUT_W-1:0])); // R5
    AST_WRAP_LOWBITS: assert property (@(posedge clk) disable iff (rst) (omode == OM_WRAP) |-> (data == aligned[OUT_W-1:0])); // R6

endmodule

// File: rtl/fxc_delay.sv
module fxc_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 1,
    parameter int VBIT  = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] regs [DEPTH];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) begin
                        regs[i] <= '0;
                    end
                end else begin
                    regs[0] <= d;
                    for (int i = 1; i < DEPTH; i++) begin
                        regs[i] <= regs[i-1];
                    end
                end
            end

            assign q = regs[DEPTH-1];

            for (genvar s = 0; s < DEPTH; s++) begin : g_chk
                if (s == 0) begin : g_first
                    AST_VALID_STEP: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (regs[0][VBIT] == $past(d[VBIT]))); // R10
                end else begin : g_next
                    AST_VALID_STEP: assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> (regs[s][VBIT] == $past(regs[s-1][VBIT]))); // R10
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fxc_convert.sv
module fxc_convert
    import fxc_pkg::*;
#(
    parameter int IN_W       = 12,
    parameter int IN_FRAC    = 6,
    parameter bit IN_SIGNED  = 1'b1,
    parameter int OUT_W      = 8,
    parameter int OUT_FRAC   = 3,
    parameter bit OUT_SIGNED = 1'b1,
    parameter int LATENCY    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IN_W-1:0]  in_data,
    input  logic             in_valid,
    input  logic             quant_sel,
    input  logic             ovf_sel,
    output logic [OUT_W-1:0] out_data,
    output logic             out_valid,
    output logic             out_ovf
);

    localparam int LSH      = fxc_lshift(IN_FRAC, OUT_FRAC);
    localparam int WW       = fxc_max(IN_W + LSH, OUT_W) + 2;
    localparam int SAMPLE_W = OUT_W + 2;

    typedef struct packed {
        logic             valid;
        logic             ovf;
        logic [OUT_W-1:0] data;
    } sample_t;

    generate
        if (IN_FRAC < 0 || IN_FRAC > IN_W || OUT_FRAC < 0 || OUT_FRAC > OUT_W
            || IN_W < 1 || OUT_W < 2 || LATENCY < 0) begin : g_bad_param
            $error("fxc_convert: binary point or width parameter out of range");
        end
    endgenerate

    quant_mode_e          qmode;
    ovf_mode_e            omode;
    logic signed [WW-1:0] aligned;
    logic [OUT_W-1:0]     conv_data;
    logic                 conv_oor;
    sample_t              cur;
    sample_t              dly;

    assign qmode = quant_mode_e'(quant_sel);
    assign omode = ovf_mode_e'(ovf_sel);

    fxc_quantize #(
        .IN_W      (IN_W),
        .IN_FRAC   (IN_FRAC),
        .IN_SIGNED (IN_SIGNED),
        .OUT_FRAC  (OUT_FRAC),
        .WW        (WW)
    ) u_quant (
        .clk     (clk),
        .rst     (rst),
        .din     (in_data),
        .qmode   (qmode),
        .aligned (aligned)
    );

    fxc_overflow #(
        .WW         (WW),
        .OUT_W      (OUT_W),
        .OUT_SIGNED (OUT_SIGNED)
    ) u_ovf (
        .clk          (clk),
        .rst          (rst),
        .aligned      (aligned),
        .omode        (omode),
        .data         (conv_data),
        .out_of_range (conv_oor)
    );

    always_comb begin
        cur.valid = in_valid;
        cur.ovf   = in_valid & conv_oor;
        cur.data  = conv_data;
    end

    fxc_delay #(
        .W     (SAMPLE_W),
        .DEPTH (LATENCY),
        .VBIT  (SAMPLE_W - 1)
    ) u_dly (
        .clk (clk),
        .rst (rst),
        .d   (cur),
        .q   (dly)
    );

    assign out_data  = dly.data;
    assign out_valid = dly.valid;
    assign out_ovf   = dly.ovf;

    AST_OVF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) out_ovf |-> out_valid); // R9

endmodule

// File: tb/fxc_convert_bench.sv
module fxc_convert_bench;

    typedef struct packed {
        int x;
        bit q;
        bit o;
        int d;
        bit f;
        int req;
    } vec_t;

    // x in units of 1/64, expected output code in units of 1/8 (signed 8-bit)
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{40,    0, 1, 32'h05, 0, 1},  // R1 exact 5/8
        '{43,    0, 0, 32'h05, 0, 2},  // R2 5.375 -> 5
        '{-43,   0, 0, 32'hFA, 0, 2},  // R2 -5.375 -> -6
        '{44,    1, 1, 32'h06, 0, 3},  // R3 tie 5.5 -> 6
        '{-44,   1, 1, 32'hFA, 0, 3},  // R3 tie -5.5 -> -6
        '{-42,   1, 0, 32'hFB, 0, 3},  // R3 -5.25 -> -5
        '{1020,  0, 1, 32'h7F, 0, 4},  // R4 truncate stays in range
        '{1020,  1, 1, 32'h7F, 1, 4},  // R4 rounding carry saturates
        '{1020,  1, 0, 32'h80, 1, 4},  // R4 rounding carry wraps
        '{-1025, 1, 1, 32'h80, 0, 4},  // R4 rounds back into range
        '{2047,  0, 1, 32'h7F, 1, 5},  // R5 clamp high
        '{-2048, 0, 1, 32'h80, 1, 5},  // R5 clamp low
        '{-1024, 0, 1, 32'h80, 0, 5},  // R5 exact lower limit
        '{-1025, 0, 1, 32'h80, 1, 5},  // R5 one step below
        '{2047,  0, 0, 32'hFF, 1, 6},  // R6 wrap 255
        '{-1100, 0, 0, 32'h76, 1, 6},  // R6 wrap -138
        '{-1028, 1, 1, 32'h80, 1, 8}   // R8 tie below limit flags
    };

    logic        clk;
    logic        rst;
    logic [11:0] in_data;
    logic        in_valid;
    logic        quant_sel;
    logic        ovf_sel;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ovf;
    logic [7:0]  u_data;
    logic        u_valid;
    logic        u_ovf;

    int n_checks;
    int n_fail;

    fxc_convert u_fxc_convert (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .quant_sel (quant_sel),
        .ovf_sel   (ovf_sel),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ovf   (out_ovf)
    );

    fxc_convert #(.OUT_SIGNED(1'b0)) u_fxc_convert_uns (
        .clk       (clk),
        .rst       (rst),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .quant_sel (quant_sel),
        .ovf_sel   (ovf_sel),
        .out_data  (u_data),
        .out_valid (u_valid),
        .out_ovf   (u_ovf)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int x, input bit q, input bit o, input bit v);
        @(negedge clk);
        in_data   = x[11:0];
        quant_sel = q;
        ovf_sel   = o;
        in_valid  = v;
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        n_checks  = 0;
        n_fail    = 0;
        rst       = 1'b1;
        in_data   = 12'h7FF;
        in_valid  = 1'b1;
        quant_sel = 1'b0;
        ovf_sel   = 1'b1;
        step;
        step;
        // R10 reset clears the pipeline even with a valid overflowing input
        check("R10", "reset out_valid", int'(out_valid), 0);
        check("R10", "reset out_ovf", int'(out_ovf), 0);
        check("R10", "reset out_data", int'(out_data), 0);

        drive(0, 0, 1, 0);
        rst = 1'b0;
        step;

        // R10 latency of one cycle
        drive(40, 0, 1, 1);
        #1;
        check("R10", "valid before edge", int'(out_valid), 0);
        step;
        check("R10", "valid after edge", int'(out_valid), 1);
        check("R10", "data after edge", int'(out_data), 32'h05);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].x, VECS[i].q, VECS[i].o, 1'b1);
            step;
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d data", i), int'(out_data), VECS[i].d);
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d ovf", i), int'(out_ovf), int'(VECS[i].f));
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d valid", i), int'(out_valid), 1);
        end

        // R8 flag drops for an in-range sample right after an overflow
        drive(2047, 0, 0, 1);
        step;
        check("R8", "ovf in wrap", int'(out_ovf), 1);
        drive(16, 1, 0, 1);
        step;
        check("R8", "ovf cleared", int'(out_ovf), 0);
        check("R8", "data 2", int'(out_data), 32'h02);

        // R9 invalid sample stays invalid and raises no flag
        drive(2047, 0, 1, 0);
        step;
        check("R9", "invalid out_valid", int'(out_valid), 0);
        check("R9", "invalid out_ovf", int'(out_ovf), 0);
        check("R9", "invalid uns ovf", int'(u_ovf), 0);

        // R7 unsigned output instance
        drive(-8, 0, 1, 1);
        step;
        check("R7", "uns neg sat data", int'(u_data), 0);
        check("R7", "uns neg sat ovf", int'(u_ovf), 1);
        drive(-8, 0, 0, 1);
        step;
        check("R7", "uns neg wrap data", int'(u_data), 32'hFF);
        drive(2047, 0, 1, 1);
        step;
        check("R7", "uns top code data", int'(u_data), 32'hFF);
        check("R7", "uns top code ovf", int'(u_ovf), 0);
        drive(2047, 1, 1, 1);
        step;
        check("R7", "uns round over data", int'(u_data), 32'hFF);
        check("R7", "uns round over ovf", int'(u_ovf), 1);
        check("R7", "uns valid", int'(u_valid), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule